// File: doc/BRIEF.md
# Shadow-Backed Configuration Register Bank

This block holds a small set of 16-bit control registers whose power-up contents come from a matching set of nonvolatile shadow words. The set is one module configuration word, one test word, two base-address words, one control word and a parameterised number of bootstrap words. When reset is released, a load sequencer copies each shadow word into its live register, one register per cycle. It then raises a ready flag and opens the run-time register port. Software reads and writes the live registers through a single-cycle write port and a combinational read port.

A second port programs or erases individual shadow words, using the same addresses as the live registers. A separate strobe erases every shadow word at once, and it is meant to be driven by an erase of the main memory array. Shadow storage follows flash rules. An erased word reads as all ones. Programming can only clear bits, so a programmed word becomes the AND of its old contents and the new data. A programmed value reaches its live register only at the next reset. Run-time writes never reach the shadow words.

The stop, freeze, boot, lock and address-space fields of the configuration word are driven out as live outputs. The 2 KiB-aligned array base block number is also driven out. A lock bit protects the configuration word, the base-address words and the bootstrap words against writes, and a set stop bit lifts that protection. An active-low strap pin, sampled while reset is held, can force stop on.

Top module: `cfgbank_shadowed`

## Requirements
- R1: While `rst` is high, `cfg_ready` is low and every live field output reads 0. After `rst` falls, `cfg_ready` rises after exactly NREG+1 rising clock edges (NREG = 5 + NUM_BOOT) and stays high until the next reset.
- R2: The load sequencer visits register indices 0 to NREG-1 in ascending order, one per cycle. Each live register takes its shadow word ANDed with that register's active-bit mask.
- R3: A shadow program stores the AND of the old shadow word and the new data. It leaves every live register unchanged until the next reset.
- R4: Run-time writes to live registers never change any shadow word, as seen through the values loaded at the next reset.
- R5: A shadow erase of one address sets that shadow word to 16'hFFFF. The array-erase strobe sets all shadow words to 16'hFFFF.
- R6: After reset, STOP (configuration bit 15) is 1 if the shadow STOP bit is 1 or if `strap_n` was low during reset. Otherwise it is 0.
- R7: The gated registers are address 0 (configuration), 2 (base high), 3 (base low) and addresses 5 and above (bootstrap). They ignore writes when LOCK (bit 11) is 1 and STOP is 0. They accept writes when LOCK is 0 or STOP is 1. Addresses 1 (test) and 4 (control) always accept writes.
- R8: The active-bit masks are as follows:
  - configuration: 16'hDB00 (STOP 15, FRZ 14, BOOT 12, LOCK 11, ASPC 9:8)
  - test: 16'h0003
  - base high: 16'h00FF
  - base low: 16'hF800
  - control: 16'h00FF
  - bootstrap: 16'hFFFF

  Reserved bits read 0 and take no write. Addresses at NREG or above read 0 and ignore writes.
- R9: Run-time writes issued while `cfg_ready` is low have no effect.
- R10: The output fields mirror the live configuration word. `base_blk` equals {base high[7:0], base low[15:11]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a reload |
| strap_n | input | 1 | Strap pin sampled during reset; low forces STOP |
| arr_erase | input | 1 | Erases all shadow words |
| sh_prog | input | 1 | Program the shadow word at `sh_addr` |
| sh_erase | input | 1 | Erase the shadow word at `sh_addr` |
| sh_addr | input | AW | Shadow word address |
| sh_wdata | input | 16 | Shadow program data |
| wr_en | input | 1 | Live register write strobe |
| wr_addr | input | AW | Live register write address |
| wr_data | input | 16 | Live register write data |
| rd_addr | input | AW | Live register read address |
| rd_data | output | 16 | Live register read data (combinational) |
| cfg_ready | output | 1 | Load sequence finished; run-time port open |
| cfg_stop | output | 1 | Live STOP field |
| cfg_frz | output | 1 | Live freeze field |
| cfg_boot | output | 1 | Live boot field |
| cfg_lock | output | 1 | Live LOCK field |
| cfg_aspc | output | 2 | Live address-space field |
| base_blk | output | 13 | Array base address bits 23:11 |

## Verification
The bench builds the block with NUM_BOOT = 4. This gives nine registers behind a 4-bit address, so seven unused addresses are reachable. The bench sweeps all sixteen write addresses under each of the four LOCK/STOP combinations, which exercises the gating of every register type and the behaviour of the unused addresses. Shadow programming, single-word erase, array erase and both strap levels are each followed by a reset. The reloaded values are then compared with a shadow model in the bench that uses AND-only programming.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int DW        = 16;
    localparam int IDX_CFG   = 0;
    localparam int IDX_TEST  = 1;
    localparam int IDX_BHI   = 2;
    localparam int IDX_BLO   = 3;
    localparam int IDX_CTRL  = 4;
    localparam int BOOT_BASE = 5;

    // configuration word bit positions
    localparam int B_STOP = 15;
    localparam int B_FRZ  = 14;
    localparam int B_BOOT = 12;
    localparam int B_LOCK = 11;
    localparam int B_ASPC = 8;

    typedef enum logic [1:0] {
        LS_HOLD,
        LS_LOAD,
        LS_RUN
    } load_state_e;

    function automatic logic [DW-1:0] reg_mask(input int unsigned idx, input int unsigned nreg);
        if (idx >= nreg)              return '0;
        else if (idx == IDX_CFG)      return 16'hDB00;
        else if (idx == IDX_TEST)     return 16'h0003;
        else if (idx == IDX_BHI)      return 16'h00FF;
        else if (idx == IDX_BLO)      return 16'hF800;
        else if (idx == IDX_CTRL)     return 16'h00FF;
        else                          return 16'hFFFF;
    endfunction

    function automatic logic reg_gated(input int unsigned idx);
        return (idx != IDX_TEST) && (idx != IDX_CTRL);
    endfunction

endpackage

// File: rtl/cfgbank_shadow_store.sv
module cfgbank_shadow_store
    import cfgbank_pkg::*;
#(
    parameter int NREG = 9,
    parameter int AW   = 4
) (
    input  logic          clk,
    input  logic          arr_erase,
    input  logic          sh_prog,
    input  logic          sh_erase,
    input  logic [AW-1:0] sh_addr,
    input  logic [DW-1:0] sh_wdata,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_word
);

    logic [DW-1:0] mem_q [NREG];

    // nonvolatile model: no reset, erase to ones, program clears bits only
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (arr_erase) begin
                mem_q[i] <= '1;
            end else if (sh_erase && (32'(sh_addr) == i)) begin
                mem_q[i] <= '1;
            end else if (sh_prog && (32'(sh_addr) == i)) begin
                mem_q[i] <= mem_q[i] & sh_wdata;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NREG; i++) begin
            if (32'(rd_idx) == i) rd_word = mem_q[i];
        end
    end

endmodule

// File: rtl/cfgbank_load_seq.sv
module cfgbank_load_seq
    import cfgbank_pkg::*;
#(
    parameter int NREG = 9,
    parameter int AW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    output logic          load_en,
    output logic [AW-1:0] load_idx,
    output logic          run
);

    localparam logic [AW-1:0] LAST_IDX = AW'(NREG - 1);

    load_state_e   state_q;
    logic [AW-1:0] idx_q;

    // state register: HOLD -> LOAD (release) -> RUN (last index loaded)
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LS_HOLD;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                LS_HOLD: begin
                    state_q <= LS_LOAD;
                    idx_q   <= '0;
                end
                LS_LOAD: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= LS_RUN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                LS_RUN: begin
                    state_q <= LS_RUN;
                end
                default: state_q <= LS_HOLD;
            endcase
        end
    end

    // outputs
    always_comb begin
        load_en  = 1'b0;
        run      = 1'b0;
        load_idx = idx_q;
        unique case (state_q)
            LS_HOLD: ;
            LS_LOAD: load_en = 1'b1;
            LS_RUN:  run     = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cfgbank_live_regs.sv
module cfgbank_live_regs
    import cfgbank_pkg::*;
#(
    parameter int NREG = 9,
    parameter int AW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          load_en,
    input  logic [AW-1:0] load_idx,
    input  logic [DW-1:0] load_word,
    input  logic          strap_low,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          cfg_stop,
    output logic          cfg_frz,
    output logic          cfg_boot,
    output logic          cfg_lock,
    output logic [1:0]    cfg_aspc,
    output logic [12:0]   base_blk
);

    logic [DW-1:0] live_q [NREG];
    logic          unlocked;

    assign unlocked = !live_q[IDX_CFG][B_LOCK] || live_q[IDX_CFG][B_STOP];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] MASK  = reg_mask(g, NREG);
        localparam logic          GATED = reg_gated(g);
        logic wr_ok;
        logic [DW-1:0] load_val;

        assign wr_ok = run && wr_en && (32'(wr_addr) == g) && (!GATED || unlocked);

        if (g == IDX_CFG) begin : g_strap
            assign load_val = (load_word & MASK) | (DW'(strap_low) << B_STOP);
        end else begin : g_plain
            assign load_val = load_word & MASK;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                live_q[g] <= '0;
            end else if (load_en && (32'(load_idx) == g)) begin
                live_q[g] <= load_val;
            end else if (wr_ok) begin
                live_q[g] <= wr_data & MASK;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (32'(rd_addr) == i) rd_data = live_q[i];
        end
    end

    assign cfg_stop = live_q[IDX_CFG][B_STOP];
    assign cfg_frz  = live_q[IDX_CFG][B_FRZ];
    assign cfg_boot = live_q[IDX_CFG][B_BOOT];
    assign cfg_lock = live_q[IDX_CFG][B_LOCK];
    assign cfg_aspc = live_q[IDX_CFG][B_ASPC +: 2];
    assign base_blk = {live_q[IDX_BHI][7:0], live_q[IDX_BLO][15:11]};

endmodule

// File: rtl/cfgbank_shadowed.sv
module cfgbank_shadowed
    import cfgbank_pkg::*;
#(
    parameter int NUM_BOOT = 4,
    localparam int NREG = BOOT_BASE + NUM_BOOT,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap_n,
    input  logic          arr_erase,
    input  logic          sh_prog,
    input  logic          sh_erase,
    input  logic [AW-1:0] sh_addr,
    input  logic [15:0]   sh_wdata,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data,
    output logic          cfg_ready,
    output logic          cfg_stop,
    output logic          cfg_frz,
    output logic          cfg_boot,
    output logic          cfg_lock,
    output logic [1:0]    cfg_aspc,
    output logic [12:0]   base_blk
);

    logic          load_en;
    logic [AW-1:0] load_idx;
    logic [DW-1:0] shadow_word;
    logic          strap_low_q;

    // strap is tracked while reset is held, frozen after release
    always_ff @(posedge clk) begin
        if (rst) strap_low_q <= !strap_n;
    end

    cfgbank_load_seq #(.NREG(NREG), .AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_idx (load_idx),
        .run      (cfg_ready)
    );

    cfgbank_shadow_store #(.NREG(NREG), .AW(AW)) u_shadow (
        .clk       (clk),
        .arr_erase (arr_erase),
        .sh_prog   (sh_prog),
        .sh_erase  (sh_erase),
        .sh_addr   (sh_addr),
        .sh_wdata  (sh_wdata),
        .rd_idx    (load_idx),
        .rd_word   (shadow_word)
    );

    cfgbank_live_regs #(.NREG(NREG), .AW(AW)) u_live (
        .clk       (clk),
        .rst       (rst),
        .run       (cfg_ready),
        .load_en   (load_en),
        .load_idx  (load_idx),
        .load_word (shadow_word),
        .strap_low (strap_low_q),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cfg_stop  (cfg_stop),
        .cfg_frz   (cfg_frz),
        .cfg_boot  (cfg_boot),
        .cfg_lock  (cfg_lock),
        .cfg_aspc  (cfg_aspc),
        .base_blk  (base_blk)
    );

endmodule

// File: rtl/cfgbank_shadowed_chk.sv
module cfgbank_shadowed_chk
    import cfgbank_pkg::*;
#(
    parameter int NREG = 9,
    parameter int AW   = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_ready,
    input logic          load_en,
    input logic [AW-1:0] load_idx,
    input logic          strap_low_q,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] rd_addr,
    input logic [15:0]   rd_data,
    input logic          cfg_stop,
    input logic          cfg_frz,
    input logic          cfg_boot,
    input logic          cfg_lock,
    input logic [1:0]    cfg_aspc,
    input logic [12:0]   base_blk
);

    AST_HELD_IN_RESET: assert property (@(posedge clk)
        rst |=> (!cfg_ready && !cfg_stop && !cfg_lock && !cfg_frz && base_blk == '0)); // R1

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |=> cfg_ready); // R1

    AST_LOAD_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (load_en && load_idx != AW'(NREG - 1)) |=> (load_en && load_idx == $past(load_idx) + 1'b1)); // R2

    AST_STRAP_FORCES_STOP: assert property (@(posedge clk) disable iff (rst)
        (load_en && load_idx == '0 && strap_low_q) |=> cfg_stop); // R6

    AST_LOCKED_CFG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_ready && wr_en && wr_addr == AW'(IDX_CFG) && cfg_lock && !cfg_stop)
        |=> $stable({cfg_stop, cfg_frz, cfg_boot, cfg_lock, cfg_aspc})); // R7

    AST_LOCKED_BASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_ready && wr_en && (wr_addr == AW'(IDX_BHI) || wr_addr == AW'(IDX_BLO)) && cfg_lock && !cfg_stop)
        |=> $stable(base_blk)); // R7

    AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |-> ((rd_data & ~reg_mask(32'(rd_addr), NREG)) == '0)); // R8

    AST_NO_LATE_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |-> !load_en); // R9

endmodule

bind cfgbank_shadowed cfgbank_shadowed_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_ready   (cfg_ready),
    .load_en     (load_en),
    .load_idx    (load_idx),
    .strap_low_q (strap_low_q),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .cfg_stop    (cfg_stop),
    .cfg_frz     (cfg_frz),
    .cfg_boot    (cfg_boot),
    .cfg_lock    (cfg_lock),
    .cfg_aspc    (cfg_aspc),
    .base_blk    (base_blk)
);

// File: tb/cfgbank_shadowed_test.sv
`timescale 1ns/1ps
module cfgbank_shadowed_test;

    localparam int NB   = 4;
    localparam int NREG = 5 + NB;
    localparam int AW   = 4;
    localparam int NADR = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strap_n = 1'b1;
    logic          arr_erase = 1'b0;
    logic          sh_prog = 1'b0;
    logic          sh_erase = 1'b0;
    logic [AW-1:0] sh_addr = '0;
    logic [15:0]   sh_wdata = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          cfg_ready, cfg_stop, cfg_frz, cfg_boot, cfg_lock;
    logic [1:0]    cfg_aspc;
    logic [12:0]   base_blk;

    int checks = 0;
    int errors = 0;
    logic [15:0] sh [NADR];
    logic [15:0] lv [NADR];

    always #2.5 clk = ~clk;

    cfgbank_shadowed #(.NUM_BOOT(NB)) uut (
        .clk(clk), .rst(rst), .strap_n(strap_n), .arr_erase(arr_erase),
        .sh_prog(sh_prog), .sh_erase(sh_erase), .sh_addr(sh_addr), .sh_wdata(sh_wdata),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cfg_ready(cfg_ready),
        .cfg_stop(cfg_stop), .cfg_frz(cfg_frz), .cfg_boot(cfg_boot),
        .cfg_lock(cfg_lock), .cfg_aspc(cfg_aspc), .base_blk(base_blk)
    );

    function automatic logic [15:0] mask_of(input int a);
        if (a >= NREG) return 16'h0000;
        case (a)
            0: return 16'hDB00;
            1: return 16'h0003;
            2: return 16'h00FF;
            3: return 16'hF800;
            4: return 16'h00FF;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic bit gated_of(input int a);
        return (a != 1) && (a != 4);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < NADR; a++) begin
            rd_addr = AW'(a);
            #0.5;
            chk(req, 32'(rd_data), 32'(lv[a]));
        end
        chk({req, "/R10 stop"}, 32'(cfg_stop), 32'(lv[0][15]));
        chk({req, "/R10 frz"},  32'(cfg_frz),  32'(lv[0][14]));
        chk({req, "/R10 boot"}, 32'(cfg_boot), 32'(lv[0][12]));
        chk({req, "/R10 lock"}, 32'(cfg_lock), 32'(lv[0][11]));
        chk({req, "/R10 aspc"}, 32'(cfg_aspc), 32'(lv[0][9:8]));
        chk({req, "/R10 base"}, 32'(base_blk), 32'({lv[2][7:0], lv[3][15:11]}));
    endtask

    task automatic do_reset(input logic strap, input bit poke);
        int n;
        @(negedge clk);
        rst = 1'b1;
        strap_n = strap;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", 32'(cfg_ready), 0);
        chk("R1 fields in reset", 32'({cfg_stop, cfg_lock, cfg_frz, base_blk}), 0);
        rst = 1'b0;
        if (poke) begin
            wr_en = 1'b1; wr_addr = AW'(4); wr_data = 16'h0000;
        end
        n = 0;
        while (!cfg_ready && n < 50) begin
            @(negedge clk);
            n++;
        end
        wr_en = 1'b0;
        chk("R1 load cycles", 32'(n), 32'(NREG + 1));
        for (int a = 0; a < NADR; a++) lv[a] = sh[a] & mask_of(a);
        if (!strap) lv[0][15] = 1'b1;
    endtask

    task automatic sh_program(input int a, input logic [15:0] d);
        @(negedge clk);
        sh_prog = 1'b1; sh_addr = AW'(a); sh_wdata = d;
        @(negedge clk);
        sh_prog = 1'b0;
        if (a < NREG) sh[a] = sh[a] & d;
    endtask

    task automatic sh_erase_one(input int a);
        @(negedge clk);
        sh_erase = 1'b1; sh_addr = AW'(a);
        @(negedge clk);
        sh_erase = 1'b0;
        if (a < NREG) sh[a] = 16'hFFFF;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < NADR; a++) sh[a] = (a < NREG) ? 16'hFFFF : 16'h0000;
        // array erase while reset is held
        @(negedge clk);
        arr_erase = 1'b1;
        @(negedge clk);
        arr_erase = 1'b0;

        // R5 R2: erased shadows load as full masks; R8 reserved bits 0
        do_reset(1'b1, 1'b0);
        check_all("R5 erased load");

        // R3: program twice, AND semantics, live untouched
        for (int a = 0; a < NREG; a++) begin
            sh_program(a, 16'hF7EF ^ 16'(a << 5));
            sh_program(a, 16'h7FFD ^ 16'(a << 9));
        end
        check_all("R3 live unchanged");
        do_reset(1'b1, 1'b0);
        check_all("R2 load after program");

        // R5: single-word erase
        sh_erase_one(4);
        do_reset(1'b1, 1'b0);
        check_all("R5 word erase");

        // R7 R8: write sweep over all addresses under each LOCK/STOP combination
        for (int c = 0; c < 4; c++) begin
            logic lk, sp;
            lk = c[0];
            sp = c[1];
            sh_erase_one(0);
            sh_program(0, 16'h64FF | (16'(sp) << 15) | (16'(lk) << 11) | 16'h4200);
            do_reset(1'b1, 1'b0);
            check_all("R6 cfg reload");
            for (int k = 1; k <= NADR; k++) begin
                int a;
                logic [15:0] d;
                a = k % NADR;
                d = 16'hA5C3 ^ 16'(a * 16'h1111) ^ 16'(c * 16'h0F0F);
                if (!gated_of(a) || !lk || sp) lv[a] = d & mask_of(a);
                wr(a, d);
            end
            check_all("R7 write sweep");
        end

        // R4: shadows unaffected by all those writes
        do_reset(1'b1, 1'b0);
        check_all("R4 shadow intact");

        // R6: strap low forces stop with shadow stop clear
        sh_erase_one(0);
        sh_program(0, 16'h7FFF);
        do_reset(1'b0, 1'b0);
        chk("R6 strap low stop", 32'(cfg_stop), 1);
        check_all("R6 strap low");
        do_reset(1'b1, 1'b0);
        chk("R6 strap high no stop", 32'(cfg_stop), 0);

        // R9: write during load ignored
        sh_erase_one(4);
        sh_program(4, 16'h005A);
        do_reset(1'b1, 1'b1);
        rd_addr = AW'(4);
        #0.5;
        chk("R9 write during load", 32'(rd_data), 32'h005A);
        check_all("R9 state");

        // R5: array erase restores all ones
        @(negedge clk);
        arr_erase = 1'b1;
        @(negedge clk);
        arr_erase = 1'b0;
        for (int a = 0; a < NREG; a++) sh[a] = 16'hFFFF;
        do_reset(1'b1, 1'b0);
        check_all("R5 array erase");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule